// File: doc/BRIEF.md
# Delay-Line Edge-Centering Sync Controller

This block steers the tap setting of an outgoing synchronization delay line so that the point where the returning sync signal is sampled sits midway between the transitions of two phase clocks. The analog delay lines, the phase clocks and the clock divider are outside the block. The block sees them through a few signals: the tap values it drives, and three one-cycle flags. Each flag reports that the transition of phase 0, of phase 1 or of the sync signal falls at the tap being applied in that cycle.

When the master enable is set, the controller sweeps the output delay across every tap and records the tap at which each phase-clock edge appears. It then parks the output delay at the midpoint of the two edges. Next it latches which output phase lies nearer the reference data clock and issues one divider phase-rotation request. After that it runs a background tracking loop. Each tracking pass sweeps a separate track delay line and records the phase-0 edge, the sync edge and the phase-1 edge. It then nudges the output delay by a programmable step toward the midpoint target. The recorded tap values stay inside the block.

Top module: `sync_center_ctrl`

## Requirements
- R1: While `master_en` is low, `mode` is 0 (idle), `out_tap` holds its value, `locked` is low and `rot_req` is low. The mode codes are: 0 idle, 1 init, 2 phase-select, 3 rotate, 4 track.
- R2: One cycle after enable, `mode` is 1 and `out_tap` is 0. In init, `out_tap` advances by one each cycle up to TAPS-1. Each phase edge is recorded at the first tap where its flag is seen. If either edge is missing by the end of the sweep, `out_tap` returns to 0 and the sweep repeats.
- R3: When an init sweep ends with both edges found, `out_tap` becomes (E0+E1)>>1, with the sum taken one bit wider than a tap, and `mode` becomes 2.
- R4: The `ref_on_ph1` value present in the phase-select cycle is registered onto `out_phase`, where it is visible from the rotate cycle onward.
- R5: `rot_req` is high for exactly one cycle, while `mode` is 3. It is followed by `mode` 4.
- R6: In track mode, `trk_tap` starts at 0 and advances by one per cycle, wrapping after TAPS-1. `out_tap` can change only on the clock edge that ends a sweep.
- R7: At the end of a valid sweep, T = (EDGE1+EDGE2)>>1, where EDGE1 is the phase-0 tap and EDGE2 the phase-1 tap. If T > S, `out_tap` rises by `step_size`. If T < S, it falls by `step_size`. If T equals S, it stays.
- R8: Tracking updates saturate: `out_tap` never goes below 0 or above TAPS-1.
- R9: A sweep counts as valid only if the phase-0 flag, then the sync flag, then the phase-1 flag are seen at strictly increasing taps. Any other sweep leaves `out_tap` unchanged.
- R10: `locked` is low until the first valid tracking sweep completes, then stays high while tracking. It clears when the enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Master operation enable |
| step_size | input | STEP_W | Tracking step in taps |
| ref_on_ph1 | input | 1 | 1 when the reference data clock lies nearer output phase 1 |
| ph0_edge | input | 1 | Phase-0 transition seen at the current tap |
| ph1_edge | input | 1 | Phase-1 transition seen at the current tap |
| sync_edge | input | 1 | Sync-input transition seen at the current track tap |
| out_tap | output | TAP_W | Output delay line tap |
| trk_tap | output | TAP_W | Track delay line tap |
| out_phase | output | 1 | Selected output phase |
| rot_req | output | 1 | Divider phase-rotation request pulse |
| mode | output | 3 | Current mode code |
| locked | output | 1 | First valid tracking update done |

## Verification
Init is run over a grid of phase-0 and phase-1 edge taps. The grid includes coincident edges, an edge at the last tap and reversed order. This separates a correct wide-sum midpoint from a truncated one, and catches a lost edge at the sweep's final tap. Tracking is driven open-loop with the sync edge placed below, above and exactly on the target. Repeated steps push the output delay into both saturation limits. Further sweeps put the sync edge on the phase-0 tap, past the phase-1 tap, or leave it out entirely; these must be rejected without moving the delay or setting the lock. A run with a missing phase edge checks that the init sweep restarts.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [2:0] {
      MODE_IDLE  = 3'd0,
      MODE_INIT  = 3'd1,
      MODE_PSEL  = 3'd2,
      MODE_ROT   = 3'd3,
      MODE_TRACK = 3'd4
   } sc_mode_e;
endpackage

// File: rtl/sc_tap_sweep.sv
// Wrapping tap counter for the track delay line.
module sc_tap_sweep #(
   parameter int TAPS  = 24,
   parameter int TAP_W = $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [TAP_W-1:0] tap,
   output logic             at_end
);
   localparam logic [TAP_W-1:0] LAST = TAP_W'(TAPS - 1);

   assign at_end = (tap == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) tap <= '0;
      else if (advance)    tap <= at_end ? '0 : tap + 1'b1;
   end
endmodule

// File: rtl/sc_edge_pair.sv
// Records the first tap at which each phase flag is seen during an init sweep.
module sc_edge_pair #(
   parameter int TAP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic             flag_a,
   input  logic             flag_b,
   input  logic [TAP_W-1:0] tap,
   output logic             both_n,
   output logic [TAP_W-1:0] mid_n
);
   logic             got_a, got_b;
   logic [TAP_W-1:0] pos_a, pos_b;
   logic             got_a_n, got_b_n;
   logic [TAP_W-1:0] pos_a_n, pos_b_n;
   logic [TAP_W:0]   sum;

   always_comb begin
      got_a_n = got_a | (en & flag_a);
      got_b_n = got_b | (en & flag_b);
      pos_a_n = got_a ? pos_a : tap;
      pos_b_n = got_b ? pos_b : tap;
      sum     = {1'b0, pos_a_n} + {1'b0, pos_b_n};
   end

   assign both_n = got_a_n & got_b_n;
   assign mid_n  = sum[TAP_W:1];

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         got_a <= 1'b0;
         got_b <= 1'b0;
         pos_a <= '0;
         pos_b <= '0;
      end else begin
         got_a <= got_a_n;
         got_b <= got_b_n;
         pos_a <= pos_a_n;
         pos_b <= pos_b_n;
      end
   end
endmodule

// File: rtl/sc_track_seq.sv
// Ordered capture of EDGE1 (phase 0), S (sync) and EDGE2 (phase 1) within one sweep.
module sc_track_seq #(
   parameter int TAP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic             ph0,
   input  logic             syn,
   input  logic             ph1,
   input  logic [TAP_W-1:0] tap,
   output logic             done_n,
   output logic [TAP_W-1:0] tgt_n,
   output logic [TAP_W-1:0] smp_n
);
   logic [1:0]       stage, stage_n;
   logic [TAP_W-1:0] e1, sv, e2;
   logic [TAP_W-1:0] e1_n, sv_n, e2_n;
   logic [TAP_W:0]   sum;

   always_comb begin
      stage_n = stage;
      e1_n    = e1;
      sv_n    = sv;
      e2_n    = e2;
      if (en) begin
         unique case (stage)
            2'd0: if (ph0) begin stage_n = 2'd1; e1_n = tap; end
            2'd1: if (syn) begin stage_n = 2'd2; sv_n = tap; end
            2'd2: if (ph1) begin stage_n = 2'd3; e2_n = tap; end
            default: ;
         endcase
      end
      sum = {1'b0, e1_n} + {1'b0, e2_n};
   end

   assign done_n = (stage_n == 2'd3);
   assign tgt_n  = sum[TAP_W:1];
   assign smp_n  = sv_n;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         stage <= 2'd0;
         e1    <= '0;
         sv    <= '0;
         e2    <= '0;
      end else begin
         stage <= stage_n;
         e1    <= e1_n;
         sv    <= sv_n;
         e2    <= e2_n;
      end
   end
endmodule

// File: rtl/sc_tap_adjust.sv
// Saturating proportional step toward the target; CLAMP_STEP limits the step to |T-S|.
module sc_tap_adjust #(
   parameter int TAPS       = 24,
   parameter int TAP_W      = 5,
   parameter int STEP_W     = 3,
   parameter bit CLAMP_STEP = 1'b0
) (
   input  logic [TAP_W-1:0]  cur,
   input  logic [STEP_W-1:0] step,
   input  logic [TAP_W-1:0]  tgt,
   input  logic [TAP_W-1:0]  smp,
   output logic [TAP_W-1:0]  nxt
);
   localparam int AW = ((TAP_W > STEP_W) ? TAP_W : STEP_W) + 1;
   localparam logic [AW-1:0] LAST = AW'(TAPS - 1);

   logic [AW-1:0] err_mag, eff, up, cur_w;

   assign cur_w   = AW'(cur);
   assign err_mag = (tgt > smp) ? AW'(tgt - smp) : AW'(smp - tgt);

   generate
      if (CLAMP_STEP) begin : g_clamp
         assign eff = (AW'(step) > err_mag) ? err_mag : AW'(step);
      end else begin : g_plain
         assign eff = AW'(step);
      end
   endgenerate

   assign up = cur_w + eff;

   always_comb begin
      if (tgt > smp)      nxt = (up > LAST) ? TAP_W'(LAST) : TAP_W'(up);
      else if (tgt < smp) nxt = (eff > cur_w) ? '0 : TAP_W'(cur_w - eff);
      else                nxt = cur;
   end
endmodule

// File: rtl/sync_center_ctrl.sv
module sync_center_ctrl
   import sc_pkg::*;
#(
   parameter int TAPS       = 24,
   parameter int STEP_W     = 3,
   parameter bit CLAMP_STEP = 1'b0,
   parameter int TAP_W      = $clog2(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_en,
   input  logic [STEP_W-1:0] step_size,
   input  logic              ref_on_ph1,
   input  logic              ph0_edge,
   input  logic              ph1_edge,
   input  logic              sync_edge,
   output logic [TAP_W-1:0]  out_tap,
   output logic [TAP_W-1:0]  trk_tap,
   output logic              out_phase,
   output logic              rot_req,
   output logic [2:0]        mode,
   output logic              locked
);
   localparam logic [TAP_W-1:0] LAST = TAP_W'(TAPS - 1);

   generate
      if (TAPS < 4) begin : g_bad_taps
         $error("sync_center_ctrl: TAPS must be at least 4");
      end
      if (STEP_W < 1) begin : g_bad_step
         $error("sync_center_ctrl: STEP_W must be at least 1");
      end
   endgenerate

   sc_mode_e         st;
   logic             in_init, in_track, init_end, trk_end;
   logic             init_both, trk_done;
   logic [TAP_W-1:0] init_mid, trk_tgt, trk_smp, adj_tap;

   assign in_init  = (st == MODE_INIT);
   assign in_track = (st == MODE_TRACK);
   assign init_end = in_init && (out_tap == LAST);

   sc_edge_pair #(.TAP_W(TAP_W)) i_edges (
      .clk(clk), .rst_n(rst_n),
      .clear(!in_init || init_end || !master_en),
      .en(in_init && master_en),
      .flag_a(ph0_edge), .flag_b(ph1_edge), .tap(out_tap),
      .both_n(init_both), .mid_n(init_mid)
   );

   sc_tap_sweep #(.TAPS(TAPS), .TAP_W(TAP_W)) i_sweep (
      .clk(clk), .rst_n(rst_n),
      .clear(!in_track),
      .advance(in_track && master_en),
      .tap(trk_tap), .at_end(trk_end)
   );

   sc_track_seq #(.TAP_W(TAP_W)) i_seq (
      .clk(clk), .rst_n(rst_n),
      .clear(!in_track || trk_end || !master_en),
      .en(in_track && master_en),
      .ph0(ph0_edge), .syn(sync_edge), .ph1(ph1_edge), .tap(trk_tap),
      .done_n(trk_done), .tgt_n(trk_tgt), .smp_n(trk_smp)
   );

   sc_tap_adjust #(.TAPS(TAPS), .TAP_W(TAP_W), .STEP_W(STEP_W),
                   .CLAMP_STEP(CLAMP_STEP)) i_adj (
      .cur(out_tap), .step(step_size), .tgt(trk_tgt), .smp(trk_smp),
      .nxt(adj_tap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= MODE_IDLE;
         out_tap   <= '0;
         out_phase <= 1'b0;
         locked    <= 1'b0;
      end else if (!master_en) begin
         st     <= MODE_IDLE;
         locked <= 1'b0;
      end else begin
         unique case (st)
            MODE_IDLE: begin
               st      <= MODE_INIT;
               out_tap <= '0;
            end
            MODE_INIT: begin
               if (init_end) begin
                  if (init_both) begin
                     out_tap <= init_mid;
                     st      <= MODE_PSEL;
                  end else begin
                     out_tap <= '0;
                  end
               end else begin
                  out_tap <= out_tap + 1'b1;
               end
            end
            MODE_PSEL: begin
               out_phase <= ref_on_ph1;
               st        <= MODE_ROT;
            end
            MODE_ROT: st <= MODE_TRACK;
            MODE_TRACK: begin
               if (trk_end && trk_done) begin
                  out_tap <= adj_tap;
                  locked  <= 1'b1;
               end
            end
            default: st <= MODE_IDLE;
         endcase
      end
   end

   assign rot_req = (st == MODE_ROT);
   assign mode    = st;
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
   parameter int TAPS   = 24,
   parameter int STEP_W = 3,
   parameter int TAP_W  = $clog2(TAPS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_en,
   input logic [STEP_W-1:0] step_size,
   input logic [TAP_W-1:0]  out_tap,
   input logic [TAP_W-1:0]  trk_tap,
   input logic              rot_req,
   input logic [2:0]        mode,
   input logic              locked
);
   function automatic int unsigned tap_dist(input logic [TAP_W-1:0] a,
                                            input logic [TAP_W-1:0] b);
      return (a > b) ? int'(a - b) : int'(b - a);
   endfunction

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |=> $stable(out_tap));

   assert_rot_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rot_req |=> !rot_req);

   assert_rot_to_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_req && master_en) |=> (mode == 3'd4));

   assert_mid_sweep_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4 && trk_tap != TAP_W'(TAPS - 1)) |=> $stable(out_tap));

   assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4 && master_en) |=>
         (tap_dist(out_tap, $past(out_tap)) <= int'($past(step_size))));

   assert_tap_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(out_tap) <= TAPS - 1);

   assert_lock_in_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (mode == 3'd4));
endmodule

bind sync_center_ctrl sc_checker #(.TAPS(TAPS), .STEP_W(STEP_W), .TAP_W(TAP_W)) i_sc_checker (
   .clk(clk), .rst_n(rst_n), .master_en(master_en), .step_size(step_size),
   .out_tap(out_tap), .trk_tap(trk_tap), .rot_req(rot_req), .mode(mode),
   .locked(locked)
);

// File: tb/test_sync_center_ctrl.sv
module test_sync_center_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int TAPS   = 24;
   localparam int STEP_W = 3;
   localparam int TAP_W  = $clog2(TAPS);
   localparam int LASTT  = TAPS - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              master_en = 1'b0;
   logic [STEP_W-1:0] step_size = '0;
   logic              ref_on_ph1 = 1'b0;
   logic              ph0_edge, ph1_edge, sync_edge;
   logic [TAP_W-1:0]  out_tap, trk_tap;
   logic              out_phase, rot_req, locked;
   logic [2:0]        mode;

   int checks = 0;
   int fails  = 0;
   int i0 = 99, i1 = 99, p0 = 99, p1 = 99, spos = 99;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sync_center_ctrl #(.TAPS(TAPS), .STEP_W(STEP_W)) i_sync_center_ctrl (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .step_size(step_size),
      .ref_on_ph1(ref_on_ph1), .ph0_edge(ph0_edge), .ph1_edge(ph1_edge),
      .sync_edge(sync_edge), .out_tap(out_tap), .trk_tap(trk_tap),
      .out_phase(out_phase), .rot_req(rot_req), .mode(mode), .locked(locked)
   );

   // Environment model: edge positions on the swept delay lines.
   always_comb begin
      ph0_edge  = (mode == 3'd1 && int'(out_tap) == i0) || (mode == 3'd4 && int'(trk_tap) == p0);
      ph1_edge  = (mode == 3'd1 && int'(out_tap) == i1) || (mode == 3'd4 && int'(trk_tap) == p1);
      sync_edge = (mode == 3'd4 && int'(trk_tap) == spos);
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_mode(input int m);
      int n = 0;
      while (int'(mode) != m && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R2 mode reached", int'(mode), m);
   endtask

   function automatic int expect_next(input int cur, input int stp);
      int t, nv;
      if (!(p0 < spos && spos < p1 && p1 <= LASTT && p0 >= 0)) return cur;
      t = (p0 + p1) >> 1;
      if (t > spos)      nv = (cur + stp > LASTT) ? LASTT : cur + stp;
      else if (t < spos) nv = (cur - stp < 0) ? 0 : cur - stp;
      else               nv = cur;
      return nv;
   endfunction

   task automatic run_init(input int a, input int b, input bit r);
      i0 = a; i1 = b; ref_on_ph1 = r;
      @(negedge clk) master_en = 1'b1;
      @(negedge clk);
      chk("R2 init mode", int'(mode), 1);
      chk("R2 init start tap", int'(out_tap), 0);
      wait_mode(2);
      chk("R3 centered tap", int'(out_tap), (a + b) >> 1);
      chk("R5 no early rot", int'(rot_req), 0);
      @(negedge clk);
      chk("R5 rotate mode", int'(mode), 3);
      chk("R5 rot pulse", int'(rot_req), 1);
      chk("R4 phase select", int'(out_phase), int'(r));
      @(negedge clk);
      chk("R5 track mode", int'(mode), 4);
      chk("R5 rot released", int'(rot_req), 0);
      chk("R6 track start tap", int'(trk_tap), 0);
      chk("R10 not locked yet", int'(locked), 0);
   endtask

   // Caller sets p0/p1/spos/step while trk_tap is 0.
   task automatic sweep(inout int exp_tap, input string tag);
      int n = 0;
      int nxt;
      while (int'(trk_tap) != LASTT && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk("R6 hold within sweep", int'(out_tap), exp_tap);
      nxt = expect_next(exp_tap, int'(step_size));
      @(negedge clk);
      chk(tag, int'(out_tap), nxt);
      chk("R6 track wrap", int'(trk_tap), 0);
      exp_tap = nxt;
   endtask

   task automatic disable_run();
      int hold;
      @(negedge clk) master_en = 1'b0;
      hold = int'(out_tap);
      @(negedge clk);
      chk("R1 idle mode", int'(mode), 0);
      chk("R10 lock cleared", int'(locked), 0);
      repeat (5) @(negedge clk);
      chk("R1 tap held", int'(out_tap), hold);
      chk("R1 no rot", int'(rot_req), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int et;
      int ia[5] = '{0, 5, 10, 16, 22};
      int ib[5] = '{0, 7, 14, 21, 23};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset mode", int'(mode), 0);
      chk("R1 reset tap", int'(out_tap), 0);
      chk("R10 reset lock", int'(locked), 0);
      chk("R1 reset rot", int'(rot_req), 0);

      // R2: missing phase-1 edge keeps restarting the init sweep
      i0 = 6; i1 = 99;
      @(negedge clk) master_en = 1'b1;
      repeat (25) @(negedge clk);
      chk("R2 sweep restarted tap", int'(out_tap), 0);
      chk("R2 still init", int'(mode), 1);
      disable_run();

      // Directed tracking: T = (2+20)>>1 = 11
      run_init(4, 14, 1'b1);
      et = 9;
      p0 = 2; p1 = 20; step_size = 3;
      spos = 2;  sweep(et, "R9 sync on phase-0 tap ignored");
      chk("R10 no lock after discard", int'(locked), 0);
      spos = 21; sweep(et, "R9 sync after phase-1 ignored");
      spos = 99; sweep(et, "R9 missing sync ignored");
      chk("R10 still unlocked", int'(locked), 0);
      spos = 5;
      sweep(et, "R7 step up");
      chk("R10 locked after valid sweep", int'(locked), 1);
      for (int k = 0; k < 5; k++) sweep(et, "R8 upper saturation");
      chk("R8 at top tap", int'(out_tap), LASTT);
      spos = 18; step_size = 5;
      for (int k = 0; k < 6; k++) sweep(et, "R8 lower saturation");
      chk("R8 at bottom tap", int'(out_tap), 0);
      spos = 11; step_size = 7;
      sweep(et, "R7 zero error no move");
      spos = 13; step_size = 2;
      sweep(et, "R7 zero floor stays");
      chk("R10 lock kept", int'(locked), 1);
      disable_run();

      // Grid over init edge pairs, one tracking sweep each
      for (int a = 0; a < 5; a++) begin
         for (int b = 0; b < 5; b++) begin
            run_init(ia[a], ib[b], 1'((a + b) % 2));
            et = (ia[a] + ib[b]) >> 1;
            p0 = ia[a] % 6;
            p1 = p0 + 8 + (ib[b] % 9);
            spos = (ia[a] + 2 * ib[b]) % 24;
            step_size = STEP_W'(1 + (a + b) % 7);
            sweep(et, "R7 grid sweep");
            chk("R10 grid lock", int'(locked),
                (p0 < spos && spos < p1 && p1 <= LASTT) ? 1 : 0);
            disable_run();
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule